// File: doc/BRIEF.md
# Inter-Processor Mailbox Interrupt Unit

This block lets eight processing agents signal one another with doorbell interrupts and exchange short messages. Every ordered sender/receiver pair has two private 32-byte slots of eight 32-bit words. The request slot carries data from the sender. The response slot carries the receiver's reply. One agent's buffers are set aside for the power-management processor by convention. The interrupt channels and the message slots are independent hardware. Software decides which slot goes with which doorbell.

All agents reach the block through one shared register port. Each access names the requesting agent on `regAgent`.

In a typical exchange:
1. The sender fills the request slot toward a target.
2. The sender writes the target's bit into its trigger register. This sets the sender's bit in the receiver's pending status.
3. The receiver's interrupt line rises if that source is enabled.
4. The receiver reads the request, may write a reply, then clears the pending bit.
5. The sender polls its observation register. The target's bit stays set until that clear, so its fall serves as the acknowledge.

Top module: `mbx_top`

## Requirements

Address decoding used by every requirement below:
- `regAddr[10]=1` selects a slot. Its fields are:
  - `regAddr[9]`: 0 = request, 1 = response.
  - `regAddr[8:6]`: sender.
  - `regAddr[5:3]`: receiver.
  - `regAddr[2:0]`: word.
- `regAddr[10]=0` selects a register of the requesting agent through `regAddr[2:0]`:
  - 0: trigger.
  - 1: observation.
  - 2: status.
  - 3: clear.
  - 4: mask (read).
  - 5: enable.
  - 6: disable.
- Status bit s of receiver r means "pending from sender s". Observation bit r of sender s mirrors status bit s of receiver r.

Requirements:
- R1: After reset, every status, mask and observation register reads zero and `irqOut` is all zero.
- R2: A trigger write by agent a with mask m sets status bit a of every receiver r where m[r]=1, several at once if m has several ones. Zero bits of m change nothing.
- R3: Observation bit r of sender a reads 1 from the trigger until receiver r clears status bit a, and 0 after that.
- R4: A clear write by agent a with mask c clears exactly the status bits where c=1. Zero bits leave pending bits unchanged.
- R5: `irqOut[r]` is the OR over s of (status bit s AND mask bit s) of agent r. It is a level that follows the register write in the next cycle and is low whenever agent r's mask is zero.
- R6: Enable writes set, and disable writes clear, only the mask bits written as one. The mask reads back at select 4.
- R7: Triggering a source that is already pending leaves it set and is not counted twice: a single clear removes it.
- R8: A request slot can be written only by its sender. Writes from any other agent are ignored. Both sender and receiver read it, and any third agent reads zero.
- R9: A response slot can be written only by its receiver. Writes from the sender are ignored, and the sender reads the reply.
- R10: Read data is valid on `regRdata` in the cycle after the read request and is zero in cycles that do not follow a read.
- R11: Slot writes do not change any status or observation bit.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAgent | input | 3 | Requesting agent |
| regAddr | input | 11 | Word address (slot or register) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the request |
| irqOut | output | 8 | Level interrupt per agent |

## Verification

Register and slot writes take effect at the clock edge that accepts them. Status, observation and mask reads, and `irqOut`, therefore reflect a write in the very next cycle. Read data arrives one edge after the request and returns to zero one edge later.

The bench drives every access on a falling edge and holds it across exactly one rising edge. It samples `irqOut` and `regRdata` on the following falling edge, which is the first point where each result is due. For the read-return-to-zero case it samples one further falling edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_AGENTS = 8;
  localparam int SLOT_WORDS = 8;
  localparam int DATA_W     = 32;
  localparam int AGENT_W    = $clog2(NUM_AGENTS);
  localparam int WORD_W     = $clog2(SLOT_WORDS);
  localparam int SLOT_IDX_W = 1 + 2 * AGENT_W + WORD_W;
  localparam int ADDR_W     = SLOT_IDX_W + 1;
  localparam int MEM_DEPTH  = 1 << SLOT_IDX_W;

  typedef enum logic [2:0] {
    SEL_TRIG = 3'd0,
    SEL_OBS  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_MASK = 3'd4,
    SEL_ENA  = 3'd5,
    SEL_DIS  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_t;

  typedef struct packed {
    logic                  bufWe;
    logic                  rdBuf;
    logic                  rdReg;
    logic                  trigSet;
    logic                  statClr;
    logic                  enSet;
    logic                  enClr;
    regSel_t               sel;
    logic [AGENT_W-1:0]    agent;
    logic [SLOT_IDX_W-1:0] slot;
  } mbxStrb_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic               valid,
  input  logic               write,
  input  logic [AGENT_W-1:0] agent,
  input  logic [ADDR_W-1:0]  addr,
  output mbxStrb_t           strb
);
  logic               isBuf;
  logic               isResp;
  logic [AGENT_W-1:0] sndr;
  logic [AGENT_W-1:0] rcvr;
  logic [AGENT_W-1:0] owner;
  logic               party;
  regSel_t            sel;

  always_comb begin
    isBuf  = addr[ADDR_W-1];
    isResp = addr[ADDR_W-2];
    sndr   = addr[WORD_W+2*AGENT_W-1 -: AGENT_W];
    rcvr   = addr[WORD_W+AGENT_W-1 -: AGENT_W];
    owner  = isResp ? rcvr : sndr;
    party  = (agent == sndr) || (agent == rcvr);
    sel    = regSel_t'(addr[2:0]);

    strb       = '0;
    strb.agent = agent;
    strb.slot  = addr[SLOT_IDX_W-1:0];
    strb.sel   = sel;
    if (valid && write) begin
      if (isBuf) begin
        strb.bufWe = (agent == owner);
      end else begin
        unique case (sel)
          SEL_TRIG: strb.trigSet = 1'b1;
          SEL_CLR:  strb.statClr = 1'b1;
          SEL_ENA:  strb.enSet   = 1'b1;
          SEL_DIS:  strb.enClr   = 1'b1;
          default:  ;
        endcase
      end
    end else if (valid) begin
      strb.rdBuf = isBuf && party;
      strb.rdReg = !isBuf;
    end
  end
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  mbxStrb_t              strb,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_AGENTS-1:0] irq
);
  // pend[r][s]: receiver r has a pending doorbell from sender s
  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] pend, pendNxt;
  logic [NUM_AGENTS-1:0][NUM_AGENTS-1:0] enMask, enMaskNxt;
  logic [NUM_AGENTS-1:0] obsVec;
  logic [DATA_W-1:0]     regVal;
  logic [DATA_W-1:0]     mem [MEM_DEPTH];
  logic                  rdSeen;

  always_comb begin
    pendNxt   = pend;
    enMaskNxt = enMask;
    for (int r = 0; r < NUM_AGENTS; r++) begin
      if (strb.trigSet && wdata[r]) pendNxt[r][strb.agent] = 1'b1;
    end
    if (strb.statClr) pendNxt[strb.agent] = pend[strb.agent] & ~wdata[NUM_AGENTS-1:0];
    if (strb.enSet)   enMaskNxt[strb.agent] = enMask[strb.agent] | wdata[NUM_AGENTS-1:0];
    if (strb.enClr)   enMaskNxt[strb.agent] = enMask[strb.agent] & ~wdata[NUM_AGENTS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= '0;
      enMask <= '0;
    end else begin
      pend   <= pendNxt;
      enMask <= enMaskNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.bufWe) mem[strb.slot] <= wdata;
  end

  always_comb begin
    for (int r = 0; r < NUM_AGENTS; r++) begin
      obsVec[r] = pend[r][strb.agent];
      irq[r]    = |(pend[r] & enMask[r]);
    end
    regVal = '0;
    unique case (strb.sel)
      SEL_OBS:  regVal[NUM_AGENTS-1:0] = obsVec;
      SEL_STAT: regVal[NUM_AGENTS-1:0] = pend[strb.agent];
      SEL_MASK: regVal[NUM_AGENTS-1:0] = enMask[strb.agent];
      default:  regVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata  <= '0;
      rdSeen <= 1'b0;
    end else begin
      rdSeen <= strb.rdBuf || strb.rdReg;
      if (strb.rdBuf)      rdata <= mem[strb.slot];
      else if (strb.rdReg) rdata <= regVal;
      else                 rdata <= '0;
    end
  end

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.trigSet |=> ((pend & ~$past(pend)) == '0));

  // R4
  no_spurious_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statClr |=> ((pend & $past(pend)) == $past(pend)));

  // R8
  owner_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWe |-> (strb.slot[SLOT_IDX_W-1]
      ? (strb.agent == strb.slot[WORD_W+AGENT_W-1 -: AGENT_W])
      : (strb.agent == strb.slot[WORD_W+2*AGENT_W-1 -: AGENT_W])));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdSeen |-> (rdata == '0));

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : gIrqChk
    // R5
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
      (enMask[g] == '0) |-> !irq[g]);
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [AGENT_W-1:0]    regAgent,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic [NUM_AGENTS-1:0] irqOut
);
  mbxStrb_t strb;

  mbx_ctrl uCtrl (
    .valid (regValid),
    .write (regWrite),
    .agent (regAgent),
    .addr  (regAddr),
    .strb  (strb)
  );

  mbx_datapath uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (regWdata),
    .rdata (regRdata),
    .irq   (irqOut)
  );
endmodule

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [2:0]  regAgent = '0;
  logic [10:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  irqOut;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mbx_top dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAgent(regAgent), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  localparam logic [10:0] A_TRIG = 11'd0, A_OBS = 11'd1, A_STAT = 11'd2,
    A_CLR = 11'd3, A_MASK = 11'd4, A_ENA = 11'd5, A_DIS = 11'd6;

  function automatic logic [10:0] slotAddr(input logic resp, input logic [2:0] s,
                                           input logic [2:0] r, input logic [2:0] w);
    return {1'b1, resp, s, r, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] ad, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAgent = a; regAddr = ad; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [10:0] ad, output logic [31:0] q);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAgent = a; regAddr = ad;
    @(negedge clk);
    regValid = 1'b0;
    q = regRdata;
  endtask

  task automatic testReset();
    logic [31:0] q;
    check("R1 irq", {24'd0, irqOut}, 32'd0);
    rd(3'd0, A_STAT, q); check("R1 status", q, 32'd0);
    rd(3'd5, A_MASK, q); check("R1 mask", q, 32'd0);
    rd(3'd7, A_OBS, q);  check("R1 obs", q, 32'd0);
  endtask

  task automatic testTrigger();
    logic [31:0] q;
    wr(3'd2, A_TRIG, 32'h12);                   // agent 2 rings agents 1 and 4
    rd(3'd1, A_STAT, q); check("R2 status rx1", q, 32'h04);
    rd(3'd4, A_STAT, q); check("R2 status rx4", q, 32'h04);
    rd(3'd0, A_STAT, q); check("R2 zero bit untouched", q, 32'h00);
    rd(3'd2, A_OBS, q);  check("R3 obs set", q, 32'h12);
    check("R5 irq masked", {24'd0, irqOut}, 32'd0);
  endtask

  task automatic testMask();
    logic [31:0] q;
    wr(3'd1, A_ENA, 32'h04);
    check("R5 irq rises", {31'd0, irqOut[1]}, 32'd1);
    check("R5 other irq low", {24'd0, irqOut & 8'hFD}, 32'd0);
    rd(3'd1, A_MASK, q); check("R6 mask set", q, 32'h04);
    wr(3'd1, A_ENA, 32'h81);
    rd(3'd1, A_MASK, q); check("R6 mask or", q, 32'h85);
    wr(3'd1, A_DIS, 32'h04);
    check("R5 irq drops on disable", {31'd0, irqOut[1]}, 32'd0);
    rd(3'd1, A_MASK, q); check("R6 mask clr", q, 32'h81);
    wr(3'd1, A_ENA, 32'h04);
    check("R5 irq back", {31'd0, irqOut[1]}, 32'd1);
  endtask

  task automatic testRetrigClear();
    logic [31:0] q;
    wr(3'd2, A_TRIG, 32'h02);                   // retrigger while pending
    rd(3'd1, A_STAT, q); check("R7 still set", q, 32'h04);
    wr(3'd1, A_CLR, 32'h00);
    rd(3'd1, A_STAT, q); check("R4 zero clear", q, 32'h04);
    wr(3'd1, A_CLR, 32'h04);
    check("R5 irq drops on clear", {31'd0, irqOut[1]}, 32'd0);
    rd(3'd1, A_STAT, q); check("R7 single clear", q, 32'h00);
    rd(3'd2, A_OBS, q);  check("R3 obs partial ack", q, 32'h10);
    wr(3'd6, A_TRIG, 32'h10);
    wr(3'd4, A_CLR, 32'h04);
    rd(3'd4, A_STAT, q); check("R4 only written bit", q, 32'h40);
    rd(3'd2, A_OBS, q);  check("R3 obs acked", q, 32'h00);
    wr(3'd4, A_CLR, 32'h40);
  endtask

  task automatic testSlots();
    logic [31:0] q;
    wr(3'd3, slotAddr(1'b0, 3'd3, 3'd5, 3'd2), 32'hA5A5_0001);
    wr(3'd5, slotAddr(1'b0, 3'd3, 3'd5, 3'd2), 32'hDEAD_BEEF);
    rd(3'd3, slotAddr(1'b0, 3'd3, 3'd5, 3'd2), q); check("R8 sender reads req", q, 32'hA5A5_0001);
    @(negedge clk); check("R10 rdata idle", regRdata, 32'd0);
    rd(3'd5, slotAddr(1'b0, 3'd3, 3'd5, 3'd2), q); check("R8 receiver reads req", q, 32'hA5A5_0001);
    rd(3'd6, slotAddr(1'b0, 3'd3, 3'd5, 3'd2), q); check("R8 third party zero", q, 32'd0);
    wr(3'd5, slotAddr(1'b1, 3'd3, 3'd5, 3'd7), 32'h0BAD_F00D);
    wr(3'd3, slotAddr(1'b1, 3'd3, 3'd5, 3'd7), 32'h1111_2222);
    rd(3'd3, slotAddr(1'b1, 3'd3, 3'd5, 3'd7), q); check("R9 sender reads reply", q, 32'h0BAD_F00D);
    rd(3'd5, A_STAT, q); check("R11 status untouched", q, 32'd0);
    rd(3'd3, A_OBS, q);  check("R11 obs untouched", q, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTrigger();
    testMask();
    testRetrigClear();
    testSlots();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule